// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter Stage

This block is a small binary counter that counts up or down on the rising clock edge. It is meant to be one stage of a wider counter. An active-low count enable gates counting. A direction input selects whether the stage increments or decrements.

An active-low load input puts a preset word onto the outputs at once, without waiting for the clock. While load is held low, counting is blocked. Two status outputs support chaining stages:

- **Terminal count flag.** It reports the top of the range when counting up and zero when counting down.
- **Ripple pulse.** It is active low and appears only during the low half of the clock, when the stage is enabled and sitting at its terminal value. It can clock the next stage, or it can pass a carry or borrow along a chain of stages that share one clock.

Top module: `updown_counter_stage`

## Requirements
- R1: While `load_n` is 0, `q` equals `preset_d` immediately, without any clock edge, and this overrides counting.
- R2: With `load_n` at 1 and `cnt_en_n` at 0, `q` changes only on a rising edge of `clk`; between edges it is stable.
- R3: With `dir_down` at 0, each enabled rising edge adds one to `q`.
- R4: With `dir_down` at 1, each enabled rising edge subtracts one from `q`.
- R5: With `load_n` at 1 and `cnt_en_n` at 1, `q` holds across clock edges, whatever the value of `dir_down`.
- R6: With `dir_down` at 0, `term_cnt` is 1 exactly when `q` is all ones (15 at the default width).
- R7: With `dir_down` at 1, `term_cnt` is 1 exactly when `q` is 0. `term_cnt` is decoded combinationally from `q` and `dir_down`, so flipping `dir_down` alone sets or clears it.
- R8: `term_cnt` does not depend on `cnt_en_n`.
- R9: `ripple_n` is 0 only while `clk` is 0, `cnt_en_n` is 0, `load_n` is 1 and `term_cnt` is 1.
- R10: `ripple_n` is 1 whenever `clk` is 1, whenever `cnt_en_n` is 1, and whenever `load_n` is 0.
- R11: Counting wraps modulo 2^WIDTH: all ones counting up goes to 0, and 0 counting down goes to all ones.
- R12: Rising clock edges while `load_n` is 0 do not change `q`. After `load_n` returns to 1, counting resumes from the loaded value on the next enabled rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; state advances on its rising edge |
| load_n | input | 1 | Active-low asynchronous preset |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| preset_d | input | WIDTH | Preset data word |
| q | output | WIDTH | Counter value |
| term_cnt | output | 1 | Direction-aware terminal-count flag |
| ripple_n | output | 1 | Active-low ripple pulse for cascading |

## Verification
A counting result passes through one register, so `q` is due just after the rising edge that follows the input change. The bench drives its inputs 2 ns after a rising edge and reads `q` 2 ns after the next one. The preset and `term_cnt` are combinational: the bench checks them 1 ns after driving `load_n`, `preset_d` or `dir_down`, with no clock edge in between. `ripple_n` depends on the clock phase. It is therefore sampled twice: 2 ns after a falling edge, where a pulse may appear, and 2 ns after the following rising edge, where it must be high.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   typedef enum logic [1:0] {
      MODE_LOAD = 2'd0,
      MODE_HOLD = 2'd1,
      MODE_UP   = 2'd2,
      MODE_DOWN = 2'd3
   } ctr_mode_e;

   function automatic ctr_mode_e decode_mode(input logic load_n,
                                             input logic cnt_en_n,
                                             input logic dir_down);
      if (!load_n)
         return MODE_LOAD;
      else if (cnt_en_n)
         return MODE_HOLD;
      else if (dir_down)
         return MODE_DOWN;
      else
         return MODE_UP;
   endfunction

endpackage

// File: rtl/ctr_next_value.sv
module ctr_next_value
   import ctr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  ctr_mode_e        mode,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] preset_d,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

   always_comb begin
      unique case (mode)
         MODE_LOAD: nxt = preset_d;
         MODE_UP:   nxt = cur + STEP;
         MODE_DOWN: nxt = cur - STEP;
         default:   nxt = cur;
      endcase
   end
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             cnt_en_n,
   input  logic             dir_down,
   input  logic [WIDTH-1:0] preset_d,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] state
);
   localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BASE = '0;

   always_ff @(posedge clk or negedge load_n) begin
      if (!load_n)
         state <= preset_d;
      else
         state <= nxt;
   end

   a_r3_step_up: assert property (@(posedge clk) disable iff (!load_n)
      (!cnt_en_n && !dir_down) |=> (state == $past(state) + WIDTH'(1)));

   a_r4_step_down: assert property (@(posedge clk) disable iff (!load_n)
      (!cnt_en_n && dir_down) |=> (state == $past(state) - WIDTH'(1)));

   a_r5_hold: assert property (@(posedge clk) disable iff (!load_n)
      cnt_en_n |=> $stable(state));

   a_r11_wrap_up: assert property (@(posedge clk) disable iff (!load_n)
      (!cnt_en_n && !dir_down && state == TOP) |=> (state == BASE));

   a_r11_wrap_down: assert property (@(posedge clk) disable iff (!load_n)
      (!cnt_en_n && dir_down && state == BASE) |=> (state == TOP));
endmodule

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic [WIDTH-1:0] val,
   input  logic             dir_down,
   output logic             term_cnt
);
   localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BASE = '0;

   generate
      if (WIDTH == 1) begin : g_single
         assign term_cnt = (val[0] != dir_down);
      end else begin : g_multi
         logic at_top, at_base;
         assign at_top   = &val;
         assign at_base  = ~|val;
         assign term_cnt = dir_down ? at_base : at_top;
      end
   endgenerate

   a_r6_tc_at_top: assert property (@(posedge clk) disable iff (!load_n)
      (term_cnt && !dir_down) |-> (val == TOP));

   a_r7_tc_at_base: assert property (@(posedge clk) disable iff (!load_n)
      (term_cnt && dir_down) |-> (val == BASE));
endmodule

// File: rtl/ctr_ripple_gate.sv
module ctr_ripple_gate (
   input  logic clk,
   input  logic load_n,
   input  logic cnt_en_n,
   input  logic term_cnt,
   output logic ripple_n
);
   logic fire;

   assign fire     = ~clk & ~cnt_en_n & load_n & term_cnt;
   assign ripple_n = ~fire;

   a_r9_pulse_needs_tc: assert property (@(posedge clk) disable iff (!load_n)
      !ripple_n |-> (term_cnt && !cnt_en_n));

   a_r10_idle_when_disabled: assert property (@(posedge clk) disable iff (!load_n)
      cnt_en_n |-> ripple_n);
endmodule

// File: rtl/updown_counter_stage.sv
module updown_counter_stage
   import ctr_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             cnt_en_n,
   input  logic             dir_down,
   input  logic [WIDTH-1:0] preset_d,
   output logic [WIDTH-1:0] q,
   output logic             term_cnt,
   output logic             ripple_n
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("updown_counter_stage: WIDTH must be 1..32");
      end
   endgenerate

   ctr_mode_e        mode;
   logic [WIDTH-1:0] state;
   logic [WIDTH-1:0] nxt;

   assign mode = decode_mode(load_n, cnt_en_n, dir_down);
   // while load is low the preset is passed straight to the outputs
   assign q    = load_n ? state : preset_d;

   ctr_next_value #(.WIDTH(WIDTH)) u_next (
      .mode     (mode),
      .cur      (state),
      .preset_d (preset_d),
      .nxt      (nxt)
   );

   ctr_state_reg #(.WIDTH(WIDTH)) u_reg (
      .clk      (clk),
      .load_n   (load_n),
      .cnt_en_n (cnt_en_n),
      .dir_down (dir_down),
      .preset_d (preset_d),
      .nxt      (nxt),
      .state    (state)
   );

   ctr_tc_decode #(.WIDTH(WIDTH)) u_tc (
      .clk      (clk),
      .load_n   (load_n),
      .val      (q),
      .dir_down (dir_down),
      .term_cnt (term_cnt)
   );

   ctr_ripple_gate u_rip (
      .clk      (clk),
      .load_n   (load_n),
      .cnt_en_n (cnt_en_n),
      .term_cnt (term_cnt),
      .ripple_n (ripple_n)
   );

   always_comb begin
      if (!load_n) a_r1_preset_visible: assert (q == preset_d);
   end
endmodule

// File: tb/sim_updown_counter_stage.sv
`timescale 1ns/1ps
module sim_updown_counter_stage;
   logic       clk = 1'b0;
   logic       load_n = 1'b1;
   logic       cnt_en_n = 1'b1;
   logic       dir_down = 1'b0;
   logic [3:0] preset_d = 4'd0;
   logic [3:0] q;
   logic       term_cnt;
   logic       ripple_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   updown_counter_stage #(.WIDTH(4)) u0 (
      .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
      .preset_d(preset_d), .q(q), .term_cnt(term_cnt), .ripple_n(ripple_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_load(input logic [3:0] v);
      preset_d = v;
      load_n = 1'b0;
      #1;
   endtask

   task automatic t_reset_load();
      #1;
      do_load(4'd5);
      chk("R1 preset visible", q, 5);
      chk("R10 ripple high under load", ripple_n, 1);
      cnt_en_n = 1'b0;
      tick(); tick();
      chk("R12 clock ignored under load", q, 5);
      @(negedge clk); #2;
      chk("R10 ripple high under load low phase", ripple_n, 1);
   endtask

   task automatic t_release_count();
      tick();
      load_n = 1'b1;
      dir_down = 1'b0;
      #1;
      chk("R12 value kept after release", q, 5);
      tick();
      chk("R12 resume from loaded value", q, 6);
      @(negedge clk); #2;
      chk("R2 no change between edges", q, 6);
      tick();
      chk("R3 count up", q, 7);
   endtask

   task automatic t_down();
      dir_down = 1'b1;
      tick();
      chk("R4 count down", q, 6);
      tick();
      chk("R4 count down again", q, 5);
   endtask

   task automatic t_hold();
      cnt_en_n = 1'b1;
      tick();
      chk("R5 hold", q, 5);
      dir_down = 1'b0;
      tick();
      chk("R5 hold with dir changed", q, 5);
      cnt_en_n = 1'b0;
   endtask

   task automatic t_top_terminal();
      do_load(4'd14);
      tick();
      load_n = 1'b1;
      dir_down = 1'b0;
      #1;
      chk("R6 no tc at 14", term_cnt, 0);
      tick();
      chk("R3 reach 15", q, 15);
      chk("R6 tc at top", term_cnt, 1);
      cnt_en_n = 1'b1;
      #1;
      chk("R8 tc ignores enable", term_cnt, 1);
      @(negedge clk); #2;
      chk("R10 ripple high when disabled", ripple_n, 1);
      @(posedge clk); #2;
      chk("R5 hold at 15", q, 15);
      dir_down = 1'b1;
      #1;
      chk("R7 dir change clears tc", term_cnt, 0);
      dir_down = 1'b0;
      #1;
      chk("R7 dir back sets tc", term_cnt, 1);
      cnt_en_n = 1'b0;
      @(negedge clk); #2;
      chk("R9 ripple low in low phase", ripple_n, 0);
      chk("R2 stable in low phase", q, 15);
      @(posedge clk); #2;
      chk("R11 wrap up to 0", q, 0);
      chk("R10 ripple high in high phase", ripple_n, 1);
      chk("R6 tc cleared at 0 up", term_cnt, 0);
   endtask

   task automatic t_base_terminal();
      dir_down = 1'b1;
      #1;
      chk("R7 tc at 0 down", term_cnt, 1);
      @(negedge clk); #2;
      chk("R9 ripple low at base", ripple_n, 0);
      @(posedge clk); #2;
      chk("R11 wrap down to 15", q, 15);
      chk("R7 tc off at 15 down", term_cnt, 0);
      @(negedge clk); #2;
      chk("R9 ripple high without tc", ripple_n, 1);
   endtask

   task automatic t_load_midcount();
      tick();
      chk("R4 count to 14", q, 14);
      preset_d = 4'd0;
      load_n = 1'b0;
      #1;
      chk("R1 async load mid count", q, 0);
      chk("R7 tc on loaded 0", term_cnt, 1);
      @(negedge clk); #2;
      chk("R10 ripple forced high by load", ripple_n, 1);
      tick();
      load_n = 1'b1;
      tick();
      chk("R12 resume down from 0", q, 15);
   endtask

   initial begin
      t_reset_load();
      t_release_count();
      t_down();
      t_hold();
      t_top_terminal();
      t_base_terminal();
      t_load_midcount();
      done = 1'b1;
   end

   initial begin : watchdog
      for (int i = 0; i < 5000; i++) begin
         if (done) break;
         @(posedge clk);
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=hung expected=finish");
      end
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule